// File: doc/BRIEF.md
# Decimal Up/Down Counter Digit

This block is one synchronous decimal digit that counts up or down on every rising clock edge while it is enabled. The direction is chosen by a single input. The count wraps at the decimal limits rather than at the binary ones: from nine up to zero, and from zero down to nine. A preset input loads any 4-bit value directly. A synchronous reset clears the count.

Two outputs support chaining digits. The terminal flag is high when the next enabled step will wrap in the current direction. The active-low ripple strobe pulses low during the low half of the clock on such a step. A following digit can use the strobe as its own enable or as its clock.

Preset values from ten to fifteen are not legal digits. They are still accepted, and the counter returns to the legal range on its own within a few steps.

Top module: `dec_counter`

## Requirements
- R1: A high `rst` at a rising clock edge sets `count` to 0. Reset wins over preset and enable.
- R2: When `preset_n` is 0 at a rising edge and `rst` is low, `count` takes `preset_val`. This happens whatever the value of `hold_n` or `dir_down`.
- R3: When `hold_n` is 1 and neither reset nor preset is active, `count` keeps its value across the edge.
- R4: When enabled with `dir_down` = 0, `count` goes up by one per edge, and 9 goes to 0.
- R5: When enabled with `dir_down` = 1, `count` goes down by one per edge, and 0 goes to 9.
- R6: `term_flag` is combinational. It is 1 exactly when `count` is 9 with `dir_down` = 0, or when `count` is 0 with `dir_down` = 1.
- R7: `ripple_n` is 0 only while `term_flag` is 1, `hold_n` is 0 and `clk` is 0. At all other times it is 1.
- R8: From a count of 10 to 15, an enabled up step gives 0. An enabled down step gives the count minus one.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; state changes on the rising edge |
| rst | input | 1 | Synchronous reset, active high |
| hold_n | input | 1 | Count enable, active low (1 = hold) |
| dir_down | input | 1 | 0 = count up, 1 = count down |
| preset_n | input | 1 | Synchronous preset strobe, active low |
| preset_val | input | 4 | Value copied in on preset |
| count | output | 4 | Current digit value |
| term_flag | output | 1 | Terminal count for the current direction |
| ripple_n | output | 1 | Active-low wrap strobe, gated by low clock phase |

## Verification
The count register is the only state in the block, and it is visible directly on `count`. A wrong next value therefore shows up on the first clock edge after the faulty step. A fault at a wrap shows up in the same cycle as a wrong `term_flag` or a missing `ripple_n` pulse during the low clock phase before the edge. The bench compares every cycle against a behavioural model. It does this during long runs in each direction, during holds, presets and direction reversals, and during recovery from illegal presets. Because of this, a wrong wrap or recovery value cannot go unseen for more than one cycle.

// File: rtl/dec_counter_pkg.sv
package dec_counter_pkg;

    typedef enum logic [2:0] {
        OP_CLEAR,
        OP_PRESET,
        OP_HOLD,
        OP_INC,
        OP_DEC
    } dec_op_e;

endpackage

// File: rtl/dec_op_sel.sv
module dec_op_sel
    import dec_counter_pkg::*;
(
    input  logic    rst,
    input  logic    preset_n,
    input  logic    hold_n,
    input  logic    dir_down,
    output dec_op_e op
);

    always_comb begin
        if (rst) begin
            op = OP_CLEAR;
        end else if (!preset_n) begin
            op = OP_PRESET;
        end else if (hold_n) begin
            op = OP_HOLD;
        end else if (dir_down) begin
            op = OP_DEC;
        end else begin
            op = OP_INC;
        end
    end

endmodule

// File: rtl/dec_step.sv
module dec_step
    import dec_counter_pkg::*;
#(
    parameter int MODULUS = 10,
    localparam int CNT_W  = $clog2(MODULUS)
) (
    input  dec_op_e          op,
    input  logic [CNT_W-1:0] cur,
    input  logic [CNT_W-1:0] preset_val,
    output logic [CNT_W-1:0] nxt
);

    localparam logic [CNT_W-1:0] LAST_V = CNT_W'(MODULUS - 1);
    localparam logic [CNT_W-1:0] ONE_V  = CNT_W'(1);

    logic at_or_above_last;
    logic at_zero;

    assign at_or_above_last = (cur >= LAST_V);
    assign at_zero          = (cur == '0);

    always_comb begin
        unique case (op)
            OP_CLEAR:  nxt = '0;
            OP_PRESET: nxt = preset_val;
            OP_INC:    nxt = at_or_above_last ? '0 : cur + ONE_V;
            OP_DEC:    nxt = at_zero ? LAST_V : cur - ONE_V;
            default:   nxt = cur;
        endcase
    end

endmodule

// File: rtl/dec_term.sv
module dec_term #(
    parameter int MODULUS = 10,
    localparam int CNT_W  = $clog2(MODULUS)
) (
    input  logic             clk,
    input  logic [CNT_W-1:0] cur,
    input  logic             dir_down,
    input  logic             hold_n,
    output logic             term_flag,
    output logic             ripple_n
);

    localparam logic [CNT_W-1:0] LAST_V = CNT_W'(MODULUS - 1);

    logic hit_top;
    logic hit_bottom;

    assign hit_top    = (cur == LAST_V) && !dir_down;
    assign hit_bottom = (cur == '0) && dir_down;
    assign term_flag  = hit_top || hit_bottom;
    assign ripple_n   = !(term_flag && !hold_n && !clk);

endmodule

// File: rtl/dec_counter.sv
module dec_counter
    import dec_counter_pkg::*;
#(
    parameter int MODULUS = 10,
    localparam int CNT_W  = $clog2(MODULUS)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             hold_n,
    input  logic             dir_down,
    input  logic             preset_n,
    input  logic [CNT_W-1:0] preset_val,
    output logic [CNT_W-1:0] count,
    output logic             term_flag,
    output logic             ripple_n
);

    typedef struct packed {
        logic [CNT_W-1:0] count;
    } dec_state_t;

    dec_state_t      state_d;
    dec_state_t      state_q;
    dec_op_e         op;
    logic [CNT_W-1:0] step_nxt;

    dec_op_sel u_op_sel (
        .rst      (rst),
        .preset_n (preset_n),
        .hold_n   (hold_n),
        .dir_down (dir_down),
        .op       (op)
    );

    dec_step #(.MODULUS(MODULUS)) u_step (
        .op         (op),
        .cur        (state_q.count),
        .preset_val (preset_val),
        .nxt        (step_nxt)
    );

    dec_term #(.MODULUS(MODULUS)) u_term (
        .clk       (clk),
        .cur       (state_q.count),
        .dir_down  (dir_down),
        .hold_n    (hold_n),
        .term_flag (term_flag),
        .ripple_n  (ripple_n)
    );

    always_comb begin
        state_d       = state_q;
        state_d.count = step_nxt;
    end

    always_ff @(posedge clk) begin
        state_q <= state_d;
    end

    assign count = state_q.count;

endmodule

// File: rtl/dec_counter_chk.sv
module dec_counter_chk #(
    parameter int MODULUS = 10,
    localparam int CNT_W  = $clog2(MODULUS)
) (
    input logic             clk,
    input logic             rst,
    input logic             hold_n,
    input logic             dir_down,
    input logic             preset_n,
    input logic [CNT_W-1:0] preset_val,
    input logic [CNT_W-1:0] count,
    input logic             term_flag,
    input logic             ripple_n
);

    localparam logic [CNT_W-1:0] LAST_V = CNT_W'(MODULUS - 1);

    logic seen_reset;
    always_ff @(posedge clk) begin
        if (rst) seen_reset <= 1'b1;
        else if (seen_reset !== 1'b1) seen_reset <= 1'b0;
    end

    // R1
    p_reset_clear_r1: assert property (@(posedge clk) rst |=> count == '0);

    // R2
    p_preset_load_r2: assert property (@(posedge clk) disable iff (rst || seen_reset !== 1'b1)
        !preset_n |=> count == $past(preset_val));

    // R3
    p_hold_keep_r3: assert property (@(posedge clk) disable iff (rst || seen_reset !== 1'b1)
        (preset_n && hold_n) |=> $stable(count));

    // R4
    p_up_wrap_r4: assert property (@(posedge clk) disable iff (rst || seen_reset !== 1'b1)
        (preset_n && !hold_n && !dir_down && count == LAST_V) |=> count == '0);

    // R5
    p_down_wrap_r5: assert property (@(posedge clk) disable iff (rst || seen_reset !== 1'b1)
        (preset_n && !hold_n && dir_down && count == '0) |=> count == LAST_V);

    // R6
    p_term_up_r6: assert property (@(posedge clk) disable iff (rst || seen_reset !== 1'b1)
        (term_flag && !dir_down) |-> count == LAST_V);

    // R7
    p_ripple_gate_r7: assert property (@(posedge clk) disable iff (rst || seen_reset !== 1'b1)
        !ripple_n |-> (term_flag && !hold_n));

    // R8
    p_illegal_up_r8: assert property (@(posedge clk) disable iff (rst || seen_reset !== 1'b1)
        (preset_n && !hold_n && !dir_down && count > LAST_V) |=> count == '0);

endmodule

bind dec_counter dec_counter_chk #(.MODULUS(MODULUS)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .hold_n     (hold_n),
    .dir_down   (dir_down),
    .preset_n   (preset_n),
    .preset_val (preset_val),
    .count      (count),
    .term_flag  (term_flag),
    .ripple_n   (ripple_n)
);

// File: tb/dec_counter_tb.sv
`timescale 1ns/1ps
module dec_counter_tb;

    logic       clk = 1'b0;
    logic       rst = 1'b0;
    logic       hold_n = 1'b1;
    logic       dir_down = 1'b0;
    logic       preset_n = 1'b1;
    logic [3:0] preset_val = 4'd0;
    logic [3:0] count;
    logic       term_flag;
    logic       ripple_n;

    int checks = 0;
    int errors = 0;
    int model = 0;
    bit model_ok = 0;

    always #2 clk = ~clk;

    dec_counter u_dut (
        .clk        (clk),
        .rst        (rst),
        .hold_n     (hold_n),
        .dir_down   (dir_down),
        .preset_n   (preset_n),
        .preset_val (preset_val),
        .count      (count),
        .term_flag  (term_flag),
        .ripple_n   (ripple_n)
    );

    task automatic check(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
        end
    endtask

    // One cycle: drive at the falling edge, check the low phase, step the model at the rise.
    task automatic step(input string req, input bit r, input bit pn, input int pv,
                        input bit hn, input bit dn);
        int exp_term;
        @(negedge clk);
        rst = r; preset_n = pn; preset_val = 4'(pv); hold_n = hn; dir_down = dn;
        #1;
        if (model_ok) begin
            exp_term = ((model == 9 && !dn) || (model == 0 && dn)) ? 1 : 0;
            check(req, "count", int'(count), model);
            check("R6", "term_flag", int'(term_flag), exp_term);
            check("R7", "ripple_n low phase", int'(ripple_n), (exp_term == 1 && !hn) ? 0 : 1);
        end
        @(posedge clk);
        if (r) model = 0;
        else if (!pn) model = pv;
        else if (!hn) begin
            if (!dn) model = (model >= 9) ? 0 : model + 1;
            else model = (model == 0) ? 9 : model - 1;
        end
        model_ok = 1;
        #1;
        check("R7", "ripple_n high phase", int'(ripple_n), 1);
    endtask

    initial begin
        #800000;
        checks++;
        errors++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        // R1: reset wins over preset and enable
        step("R1", 1, 0, 5, 0, 0);
        step("R1", 1, 0, 7, 0, 1);
        step("R1", 0, 1, 0, 1, 0);
        // R4: up run past the wrap twice
        for (int i = 0; i < 22; i++) step("R4", 0, 1, 0, 0, 0);
        // R3: hold
        for (int i = 0; i < 4; i++) step("R3", 0, 1, 3, 1, 0);
        for (int i = 0; i < 3; i++) step("R3", 0, 1, 3, 1, 1);
        // R5: down run past the wrap twice
        for (int i = 0; i < 23; i++) step("R5", 0, 1, 0, 0, 1);
        // R2: preset with and without enable, both directions
        step("R2", 0, 0, 7, 1, 0);
        step("R2", 0, 0, 2, 0, 1);
        step("R2", 0, 0, 9, 0, 0);
        step("R4", 0, 1, 0, 0, 0);
        step("R2", 0, 0, 0, 1, 1);
        step("R5", 0, 1, 0, 0, 1);
        // direction reversal near the limits
        step("R4", 0, 1, 0, 0, 0);
        step("R5", 0, 1, 0, 0, 1);
        step("R5", 0, 1, 0, 0, 1);
        // R8: illegal presets
        for (int v = 10; v < 16; v++) begin
            step("R8", 0, 0, v, 0, 0);
            step("R8", 0, 1, 0, 0, 0);
            step("R8", 0, 1, 0, 0, 0);
        end
        for (int v = 10; v < 16; v++) begin
            step("R8", 0, 0, v, 1, 1);
            for (int k = 0; k < 8; k++) step("R8", 0, 1, 0, 0, 1);
        end
        // R1: reset mid-count
        step("R1", 1, 1, 0, 0, 0);
        step("R1", 0, 1, 0, 1, 0);
        step("R1", 0, 1, 0, 1, 0);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule